// File: doc/BRIEF.md
# Asynchronous Strobed Bus Slave with Burst Address Stepping

This block connects an asynchronous, strobe-driven microprocessor bus to a register file that runs on the core clock. The master presents a 9-bit address and qualifies it with an active-low address strobe and an active-low chip select. It then runs one or more data-strobe cycles, and a read/write select marks each cycle as a read (high) or a write (low). For every accepted data-strobe cycle the slave performs one access on the synchronous register-file port. It answers with an active-low acknowledge once the read data is on the bus or the write has been taken.

All bus strobes are brought into the core clock domain through two-flop synchronizers, and edge detectors turn them into single-cycle events. The address is captured once, when the address strobe falls. The first data-strobe cycle after that capture uses the captured address. Each later data-strobe cycle first advances the internal address by one and then accesses the new location, so a master can sweep a contiguous range without presenting addresses again. A new falling edge on the address strobe ends the burst and captures a fresh address.

The bidirectional data bus is presented as a separate input, output and output-enable, for a pad ring to combine. The register-file side expects `reg_rdata` to follow `reg_addr` within the same clock cycle.

Top module: `mbus_burst_slave`

## Requirements
- R1: While `rst_n` is low, `bus_ack_n` is 1, `bus_data_oe` is 0 and `reg_we` is 0.
- R2: A falling address strobe while chip select is low captures `bus_addr`. The first data-strobe cycle after it accesses exactly that captured location.
- R3: In a read cycle (`bus_rnw`=1), while `bus_ack_n` is low, `bus_data_oe` is 1 and `bus_data_o` holds the contents of the accessed location.
- R4: In a write cycle (`bus_rnw`=0), each data-strobe low period produces exactly one single-cycle `reg_we` pulse, however long the strobe stays low. The pulse carries the accessed address and the `bus_data_i` value.
- R5: Within a burst, every data-strobe cycle after the first accesses the previous location plus one.
- R6: The burst address wraps from 511 to 0.
- R7: `bus_ack_n` goes low only after the access has been performed. It returns high, and `bus_data_oe` returns low, by the third core clock edge after the data strobe returns high.
- R8: `bus_data_oe` stays 0 throughout write cycles and whenever chip select is high.
- R9: Data-strobe cycles run while chip select is high are ignored: no acknowledge, no `reg_we`, and register contents are unchanged.
- R10: A new falling edge on the address strobe ends the running burst. The next access goes to the newly captured address, not to the incremented one.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Chip select, active low (asynchronous) |
| bus_as_n | input | 1 | Address strobe, active low (asynchronous) |
| bus_ds_n | input | 1 | Data strobe, active low (asynchronous) |
| bus_rnw | input | 1 | 1 = read cycle, 0 = write cycle |
| bus_addr | input | 9 | Bus address |
| bus_data_i | input | 8 | Data bus, inbound half |
| bus_data_o | output | 8 | Data bus, outbound half |
| bus_data_oe | output | 1 | Drive enable for the outbound data |
| bus_ack_n | output | 1 | Data acknowledge, active low |
| reg_addr | output | 9 | Register-file address |
| reg_we | output | 1 | Register-file write enable, one cycle per write |
| reg_wdata | output | 8 | Register-file write data |
| reg_rdata | input | 8 | Register-file read data for `reg_addr`, same cycle |

## Verification
The bench builds the block with its default parameters: a 9-bit address, an 8-bit data path and two synchronizer stages. With those values the whole 512-location space is addressable from the bus. This lets a burst that starts at 510 cross the top and reach the wrap to 0 in a handful of cycles, and it makes the acknowledge-release bound exactly three clock edges. Bursts of one to four accesses, at the bottom, middle and top of the space, are written and then read back. A held-low strobe, a deselected cycle and a mid-burst restart are then driven on their own.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  // Phases of one data-strobe cycle as seen in the core domain
  typedef enum logic [1:0] {
    CYC_IDLE   = 2'd0,
    CYC_ACCESS = 2'd1,
    CYC_HOLD   = 2'd2
  } cyc_state_e;

endpackage

// File: rtl/mbs_sync.sv
module mbs_sync #(
  parameter int              WIDTH   = 1,
  parameter int              STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  // one independent flop chain per bit
  for (genvar g = 0; g < WIDTH; g++) begin : g_lane
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL[g]}};
      else        chain <= {chain[STAGES-2:0], d[g]};
    end
    assign q[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/mbs_addr_track.sv
module mbs_addr_track #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          as_fall_ok,
  input  logic          acc_start,
  input  logic [AW-1:0] bus_addr,
  output logic [AW-1:0] addr_q
);

  logic first_q;

  // next location of a burst; wraps naturally at the top of the space
  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      first_q <= 1'b1;
    end else if (as_fall_ok) begin
      addr_q  <= bus_addr;
      first_q <= 1'b1;
    end else if (acc_start) begin
      if (!first_q) addr_q <= step_addr(addr_q);
      first_q <= 1'b0;
    end
  end

  // R2: capture on address strobe
  p_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
    as_fall_ok |=> addr_q == $past(bus_addr));

  // R5: later cycles move the address by exactly one
  p_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !first_q && !as_fall_ok) |=> (addr_q - $past(addr_q)) == AW'(1));

  // R6: top of space wraps to zero
  p_wrap_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && !first_q && !as_fall_ok && (&addr_q)) |=> addr_q == '0);

  // R2: first access after a capture leaves the address untouched
  p_first_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_start && first_q && !as_fall_ok) |=> $stable(addr_q));

endmodule

// File: rtl/mbs_cycle_fsm.sv
module mbs_cycle_fsm
  import mbs_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ds_fall,
  input  logic          ds_high,
  input  logic          cs_low,
  input  logic          rnw_s,
  input  logic [DW-1:0] bus_data_i,
  input  logic [DW-1:0] reg_rdata,
  output logic          acc_start,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] data_o,
  output logic          data_oe,
  output logic          ack_n,
  output logic          in_hold
);

  cyc_state_e state;
  logic       rnw_l;

  assign acc_start = (state == CYC_IDLE) && ds_fall && cs_low;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CYC_IDLE;
      rnw_l     <= 1'b1;
      reg_wdata <= '0;
      data_o    <= '0;
    end else begin
      unique case (state)
        CYC_IDLE: if (acc_start) begin
          state     <= CYC_ACCESS;
          rnw_l     <= rnw_s;
          reg_wdata <= bus_data_i;
        end
        CYC_ACCESS: begin
          data_o <= reg_rdata;
          state  <= CYC_HOLD;
        end
        CYC_HOLD: if (ds_high) state <= CYC_IDLE;
        default: state <= CYC_IDLE;
      endcase
    end
  end

  assign in_hold = (state == CYC_HOLD);
  assign reg_we  = (state == CYC_ACCESS) && !rnw_l;
  assign ack_n   = !in_hold;
  assign data_oe = in_hold && rnw_l && cs_low;

  // R4: a write strobe never lasts two cycles
  p_single_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we |=> !reg_we);

  // R8: drive only while acknowledging a read with chip select low
  p_oe_guard_r8: assert property (@(posedge clk) disable iff (!rst_n)
    data_oe |-> (!ack_n && cs_low && rnw_l));

  // R7: acknowledge only follows a completed access
  p_ack_after_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ack_n) |-> $past(state == CYC_ACCESS));

endmodule

// File: rtl/mbus_burst_slave.sv
module mbus_burst_slave #(
  parameter int AW          = 9,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_cs_n,
  input  logic          bus_as_n,
  input  logic          bus_ds_n,
  input  logic          bus_rnw,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_data_i,
  output logic [DW-1:0] bus_data_o,
  output logic          bus_data_oe,
  output logic          bus_ack_n,
  output logic [AW-1:0] reg_addr,
  output logic          reg_we,
  output logic [DW-1:0] reg_wdata,
  input  logic [DW-1:0] reg_rdata
);

  localparam int NSTB = 4;

  logic [NSTB-1:0] stb_raw, stb_s;
  logic cs_s, as_s, ds_s, rnw_s;
  logic as_prev, ds_prev;
  logic as_fall, ds_fall, ds_rise;
  logic as_fall_ok, acc_start, in_hold;

  assign stb_raw = {bus_rnw, bus_ds_n, bus_as_n, bus_cs_n};
  assign {rnw_s, ds_s, as_s, cs_s} = stb_s;

  mbs_sync #(.WIDTH(NSTB), .STAGES(SYNC_STAGES), .RST_VAL('1)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(stb_raw), .q(stb_s));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      as_prev <= 1'b1;
      ds_prev <= 1'b1;
    end else begin
      as_prev <= as_s;
      ds_prev <= ds_s;
    end
  end

  assign as_fall    = as_prev && !as_s;
  assign ds_fall    = ds_prev && !ds_s;
  assign ds_rise    = !ds_prev && ds_s;
  assign as_fall_ok = as_fall && !cs_s;

  mbs_addr_track #(.AW(AW)) u_addr (
    .clk(clk), .rst_n(rst_n), .as_fall_ok(as_fall_ok), .acc_start(acc_start),
    .bus_addr(bus_addr), .addr_q(reg_addr));

  mbs_cycle_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_n), .ds_fall(ds_fall), .ds_high(ds_s), .cs_low(!cs_s),
    .rnw_s(rnw_s), .bus_data_i(bus_data_i), .reg_rdata(reg_rdata),
    .acc_start(acc_start), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .data_o(bus_data_o), .data_oe(bus_data_oe), .ack_n(bus_ack_n), .in_hold(in_hold));

  // R7: a synchronized strobe release drops the acknowledge on the next edge
  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (ds_rise && in_hold) |=> (bus_ack_n && !bus_data_oe));

  // R9: an idle slave stays silent while deselected
  p_deselect_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_s && bus_ack_n) |=> (bus_ack_n && !reg_we));

endmodule

// File: tb/tb_mbus_burst_slave.sv
module tb_mbus_burst_slave;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic       rst_n;
  logic       cs_n, as_n, ds_n, rnw;
  logic [8:0] bus_addr;
  logic [7:0] data_i, data_o;
  logic       data_oe, ack_n;
  logic [8:0] reg_addr;
  logic       reg_we;
  logic [7:0] reg_wdata, reg_rdata;

  logic [7:0] mem [512];
  int we_count = 0;
  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // entries: {start address, burst length, first data byte}
  localparam logic [20:0] VEC [4] = '{
    {9'h000, 4'd1, 8'h11},
    {9'h040, 4'd4, 8'hA0},
    {9'h1FE, 4'd4, 8'h30},
    {9'h123, 4'd3, 8'h5C}
  };

  mbus_burst_slave dut (
    .clk(clk), .rst_n(rst_n), .bus_cs_n(cs_n), .bus_as_n(as_n), .bus_ds_n(ds_n),
    .bus_rnw(rnw), .bus_addr(bus_addr), .bus_data_i(data_i), .bus_data_o(data_o),
    .bus_data_oe(data_oe), .bus_ack_n(ack_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata));

  // core-side register file model
  assign reg_rdata = mem[reg_addr];
  always @(posedge clk) begin
    if (reg_we) begin
      mem[reg_addr] <= reg_wdata;
      we_count <= we_count + 1;
    end
  end

  function automatic logic [7:0] init_val(input int i);
    return 8'(i) ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic open_burst(input logic [8:0] a);
    @(negedge clk);
    bus_addr = a; cs_n = 1'b0; as_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic close_burst();
    as_n = 1'b1; cs_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic restrobe(input logic [8:0] a);
    as_n = 1'b1;
    repeat (4) @(negedge clk);
    bus_addr = a; as_n = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic bus_cycle(input bit rd, input logic [7:0] wd, input int hold,
                           input bit accept, output logic [7:0] rv);
    int  we0;
    int  n;
    bit  got;
    we0 = we_count;
    rnw = rd; data_i = wd; ds_n = 1'b0;
    n = 0;
    while (ack_n && n < 20) begin @(negedge clk); n++; end
    got = !ack_n;
    rv  = data_o;
    if (got) begin
      if (rd) chk(data_oe == 1'b1, "R3", "drive enable during read ack", data_oe, 1);
      else    chk(data_oe == 1'b0, "R8", "drive enable during write ack", data_oe, 0);
    end
    if (!accept) begin
      chk(!got, "R9", "acknowledge while deselected", got, 0);
      chk(data_oe == 1'b0, "R8", "drive enable while deselected", data_oe, 0);
    end else begin
      chk(got, "R7", "acknowledge seen", got, 1);
    end
    repeat (hold) @(negedge clk);
    ds_n = 1'b1;
    n = 0;
    while (!ack_n && n < 10) begin @(negedge clk); n++; end
    if (got) begin
      chk(n <= 3, "R7", "clocks until acknowledge release", n, 3);
      chk(data_oe == 1'b0, "R7", "drive enable after release", data_oe, 0);
    end
    repeat (2) @(negedge clk);
    chk((we_count - we0) == ((accept && !rd) ? 1 : 0), accept ? "R4" : "R9",
        "write pulses in one strobe", we_count - we0, (accept && !rd) ? 1 : 0);
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  initial begin
    logic [7:0] rv;
    for (int i = 0; i < 512; i++) mem[i] = init_val(i);
    rst_n = 1'b0; cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1; rnw = 1'b1;
    bus_addr = '0; data_i = '0;
    repeat (5) @(negedge clk);
    chk(ack_n == 1'b1, "R1", "ack in reset", ack_n, 1);
    chk(data_oe == 1'b0, "R1", "drive enable in reset", data_oe, 0);
    chk(reg_we == 1'b0, "R1", "write enable in reset", reg_we, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R2: single read of an untouched location
    open_burst(9'h1A0);
    bus_cycle(1'b1, 8'h00, 1, 1'b1, rv);
    close_burst();
    chk(rv == init_val(9'h1A0), "R2", "single read at captured address", rv, init_val(9'h1A0));

    // table of bursts: write then read back
    for (int k = 0; k < 4; k++) begin
      logic [8:0] a;
      int         len;
      logic [7:0] sd;
      a = VEC[k][20:12]; len = int'(VEC[k][11:8]); sd = VEC[k][7:0];
      open_burst(a);
      for (int i = 0; i < len; i++) bus_cycle(1'b0, sd + 8'(i), 1, 1'b1, rv);
      close_burst();
      for (int i = 0; i < len; i++) begin
        logic [8:0] loc;
        loc = a + 9'(i);
        chk(mem[loc] == sd + 8'(i), (int'(a) + i > 511) ? "R6" : "R5",
            "burst write contents", mem[loc], sd + 8'(i));
      end
      open_burst(a);
      for (int i = 0; i < len; i++) begin
        bus_cycle(1'b1, 8'h00, 1, 1'b1, rv);
        chk(rv == sd + 8'(i), (int'(a) + i > 511) ? "R6" : "R3",
            "burst read data", rv, sd + 8'(i));
      end
      close_burst();
    end

    // R4: strobe held low for many clocks gives one write
    open_burst(9'h0C3);
    bus_cycle(1'b0, 8'hD7, 25, 1'b1, rv);
    close_burst();
    chk(mem[9'h0C3] == 8'hD7, "R4", "long strobe write contents", mem[9'h0C3], 8'hD7);

    // R9: deselected strobe cycle leaves everything alone
    @(negedge clk);
    bus_addr = 9'h0C3; cs_n = 1'b1; as_n = 1'b0;
    repeat (4) @(negedge clk);
    bus_cycle(1'b0, 8'hEE, 3, 1'b0, rv);
    bus_cycle(1'b1, 8'h00, 3, 1'b0, rv);
    as_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(mem[9'h0C3] == 8'hD7, "R9", "contents after deselected write", mem[9'h0C3], 8'hD7);

    // R10: a new address strobe restarts at the new address
    open_burst(9'h080);
    bus_cycle(1'b0, 8'h61, 1, 1'b1, rv);
    bus_cycle(1'b0, 8'h62, 1, 1'b1, rv);
    restrobe(9'h090);
    bus_cycle(1'b0, 8'h77, 1, 1'b1, rv);
    close_burst();
    chk(mem[9'h081] == 8'h62, "R5", "second burst location", mem[9'h081], 8'h62);
    chk(mem[9'h090] == 8'h77, "R10", "write after restrobe", mem[9'h090], 8'h77);
    chk(mem[9'h082] == init_val(9'h082), "R10", "old burst not continued",
        mem[9'h082], init_val(9'h082));

    done = 1'b1;
    finish_run();
  end

endmodule